// File: doc/BRIEF.md
# Double-Late-Write Pipelined SRAM Core

This block is a synchronous single-port memory. Its data word is made of byte lanes of nine bits each, eight lanes by default, and its depth is a parameter. Each command is captured on one rising clock edge: an address, an active-low write strobe, two chip selects and one active-low enable per byte lane. Write data for a command is taken two edges after the address edge. Read data leaves through an output register at the same two-edge latency. Because both directions have the same latency, a stream of reads and writes can alternate on consecutive cycles and the data bus stays busy every cycle.

A write is held in a short command pipeline until its data arrives, and it is committed to storage on that same edge. A read looks up storage one edge after its address edge. On that edge it merges in any bytes that an older write is committing at the same moment, so a read always sees every write issued before it.

The bus is modelled as a data vector with a separate output-enable flag. A deselect lets the access already in flight finish before the bus is released. A separate echo-clock enable follows only the secondary chip select, delayed by the same two cycles.

Top module: `dlw_sram`

## Requirements
- R1: After the asynchronous reset, `oe_o`, `echo_en_o` and `rdata_o` are 0, and every storage word reads back as 0.
- R2: A cycle is selected when `ce1_ni` is low and `ce2_i` is high at the rising edge. A selected cycle with `we_ni` high is a read, whatever the value of `be_ni`.
- R3: For a selected write captured at edge n, `wdata_i` is sampled at edge n+2. Byte lane k, bits [9k+8:9k], is stored only when `be_ni[k]` is low.
- R4: A selected write with every bit of `be_ni` high leaves storage unchanged.
- R5: For a selected read captured at edge n, `rdata_o` is updated at edge n+2 and `oe_o` is high for that one cycle. `rdata_o` holds its value in every cycle that does not complete a read.
- R6: A read returns all bytes written by every earlier write, including a write issued one cycle earlier whose data is only sampled on the edge where the read looks up storage.
- R7: Reads and writes may alternate on consecutive cycles with no idle cycle, and each one completes with the R3 and R5 latencies.
- R8: A deselected cycle or a write cycle captured at edge n leaves `oe_o` low after edge n+2. A read issued in the cycle before a deselect still drives the bus for its own cycle.
- R9: `echo_en_o` after edge n+2 equals `ce2_i` sampled at edge n, and is independent of `ce1_ni` and `we_ni`.
- R10: A write attempted while deselected, with `ce1_ni` high or `ce2_i` low, leaves storage unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; everything is sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| we_ni | input | 1 | Write strobe, active low; high selects a read |
| ce1_ni | input | 1 | Primary chip select, active low |
| ce2_i | input | 1 | Secondary chip select, active high; also gates the echo enable |
| be_ni | input | BYTES | Per-lane write enables, active low |
| wdata_i | input | DATA_W | Write data, due two edges after its address |
| rdata_o | output | DATA_W | Registered read data |
| oe_o | output | 1 | High when `rdata_o` carries a completed read |
| echo_en_o | output | 1 | Echo-clock enable |

## Verification
The bench drives `wdata_i` with unrelated values in every cycle where no data is due. A design that samples write data one edge early or late therefore stores those values instead of the write's own data. It places a read directly after a write to the same address, and also one cycle later. A design without the merge on the lookup edge returns the stale word in the first case, and one that merges on the wrong cycle breaks the second. Aborted writes and deselected writes are followed by reads of the same words, so a design that commits them is exposed. Random mixes of reads, writes and deselects on both chip selects expose a bus enable or echo enable that is off by a cycle, or that reacts to the wrong select.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/dlw_cmd_pipe.sv
module dlw_cmd_pipe
  import dlw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic [BYTES-1:0]  be_ni,
  output op_e               s1_op_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output op_e               s2_op_o,
  output logic [ADDR_W-1:0] s2_addr_o,
  output logic [BYTES-1:0]  s2_mask_o,
  output logic              s2_echo_o
);
  localparam int STAGES = 2;

  op_e               op_in;
  op_e               op_q   [STAGES];
  logic [ADDR_W-1:0] addr_q [STAGES];
  logic [BYTES-1:0]  mask_q [STAGES];
  logic              echo_q [STAGES];

  always_comb begin
    if (ce1_ni || !ce2_i) op_in = OP_IDLE;
    else if (we_ni)       op_in = OP_READ;
    else                  op_in = OP_WRITE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q[0]   <= OP_IDLE;
      addr_q[0] <= '0;
      mask_q[0] <= '0;
      echo_q[0] <= 1'b0;
    end else begin
      op_q[0]   <= op_in;
      addr_q[0] <= addr_i;
      mask_q[0] <= ~be_ni;
      echo_q[0] <= ce2_i;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        op_q[s]   <= OP_IDLE;
        addr_q[s] <= '0;
        mask_q[s] <= '0;
        echo_q[s] <= 1'b0;
      end else begin
        op_q[s]   <= op_q[s-1];
        addr_q[s] <= addr_q[s-1];
        mask_q[s] <= mask_q[s-1];
        echo_q[s] <= echo_q[s-1];
      end
    end
  end

  assign s1_op_o   = op_q[0];
  assign s1_addr_o = addr_q[0];
  assign s2_op_o   = op_q[STAGES-1];
  assign s2_addr_o = addr_q[STAGES-1];
  assign s2_mask_o = mask_q[STAGES-1];
  assign s2_echo_o = echo_q[STAGES-1];
endmodule

// File: rtl/dlw_array.sv
module dlw_array #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  parameter int BYTES  = 8,
  parameter int BYTE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [BYTES-1:0]        wr_mask_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  output logic [BYTES*BYTE_W-1:0] rd_data_o
);
  logic              same_addr;
  logic [BYTE_W-1:0] mem_q [DEPTH][BYTES];
  logic [BYTE_W-1:0] rd_q  [BYTES];

  assign same_addr = wr_en_i && (wr_addr_i == rd_addr_i);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int d = 0; d < DEPTH; d++) mem_q[d][g] <= '0;
      end else if (wr_en_i && wr_mask_i[g]) begin
        mem_q[wr_addr_i][g] <= wdata_i[g*BYTE_W +: BYTE_W];
      end
    end

    // lookup merges bytes committing on this same edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q[g] <= '0;
      end else if (rd_en_i) begin
        if (same_addr && wr_mask_i[g]) rd_q[g] <= wdata_i[g*BYTE_W +: BYTE_W];
        else                           rd_q[g] <= mem_q[rd_addr_i][g];
      end
    end

    assign rd_data_o[g*BYTE_W +: BYTE_W] = rd_q[g];
  end
endmodule

// File: rtl/dlw_out_stage.sv
module dlw_out_stage #(
  parameter int DATA_W = 72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              echo_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o,
  output logic              echo_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      oe_o      <= 1'b0;
      echo_en_o <= 1'b0;
    end else begin
      oe_o      <= rd_done_i;
      echo_en_o <= echo_i;
      if (rd_done_i) rdata_o <= rd_data_i;
    end
  end
endmodule

// File: rtl/dlw_sram.sv
module dlw_sram
  import dlw_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int BYTES  = 8,
  parameter int BYTE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic [BYTES-1:0]  be_ni,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o,
  output logic              echo_en_o
);
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [BYTES-1:0]  s2_mask;
  logic              s2_echo;
  logic [DATA_W-1:0] rd_data;

  dlw_cmd_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) cmd_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_ni     (we_ni),
    .ce1_ni    (ce1_ni),
    .ce2_i     (ce2_i),
    .be_ni     (be_ni),
    .s1_op_o   (s1_op),
    .s1_addr_o (s1_addr),
    .s2_op_o   (s2_op),
    .s2_addr_o (s2_addr),
    .s2_mask_o (s2_mask),
    .s2_echo_o (s2_echo)
  );

  dlw_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) array_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (s1_op == OP_READ),
    .rd_addr_i (s1_addr),
    .wr_en_i   (s2_op == OP_WRITE),
    .wr_addr_i (s2_addr),
    .wr_mask_i (s2_mask),
    .wdata_i   (wdata_i),
    .rd_data_o (rd_data)
  );

  dlw_out_stage #(.DATA_W(DATA_W)) out_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_done_i (s2_op == OP_READ),
    .rd_data_i (rd_data),
    .echo_i    (s2_echo),
    .rdata_o   (rdata_o),
    .oe_o      (oe_o),
    .echo_en_o (echo_en_o)
  );
endmodule

// File: rtl/dlw_sram_chk.sv
module dlw_sram_chk #(
  parameter int DATA_W = 72
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              oe_o,
  input logic              echo_en_o
);
  logic sel_rd;
  assign sel_rd = !ce1_ni && ce2_i && we_ni;

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!oe_o && !echo_en_o));

  assert_read_drives_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rd |=> ##2 oe_o);

  assert_quiet_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_rd |=> ##2 !oe_o);

  assert_rdata_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_rd |=> ##2 $stable(rdata_o));

  assert_echo_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce2_i |=> ##2 echo_en_o);

  assert_echo_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce2_i |=> ##2 !echo_en_o);
endmodule

bind dlw_sram dlw_sram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_ni     (we_ni),
  .ce1_ni    (ce1_ni),
  .ce2_i     (ce2_i),
  .rdata_o   (rdata_o),
  .oe_o      (oe_o),
  .echo_en_o (echo_en_o)
);

// File: tb/dlw_sram_tb_top.sv
`timescale 1ns/1ps
module dlw_sram_tb_top;
  localparam int DEPTH = 16;
  localparam int BYTES = 8;
  localparam int BW    = 9;
  localparam int AW    = 4;
  localparam int DW    = BYTES * BW;

  typedef struct {
    bit             sel;
    bit             wr;
    int             addr;
    logic [7:0]     be_n;
    logic [DW-1:0]  wd;
    bit             ce2;
  } cmd_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          we_ni = 1'b1;
  logic          ce1_ni = 1'b1;
  logic          ce2_i = 1'b0;
  logic [7:0]    be_ni = '1;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          oe_o;
  logic          echo_en_o;

  int            checks = 0;
  int            errors = 0;
  string         cur_req = "R1";
  cmd_t          hist[$];
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_rd = '0;
  bit            exp_oe = 0;
  bit            exp_echo = 0;

  always #10 clk_i = ~clk_i;

  dlw_sram #(.DEPTH(DEPTH), .BYTES(BYTES), .BYTE_W(BW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_ni(we_ni),
    .ce1_ni(ce1_ni), .ce2_i(ce2_i), .be_ni(be_ni), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .oe_o(oe_o), .echo_en_o(echo_en_o)
  );

  function automatic logic [DW-1:0] rnd_word();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit c1n, input bit c2, input bit wn,
                     input logic [7:0] ben, input int a);
    cmd_t c;
    cmd_t old;
    c.sel  = !c1n && c2;
    c.wr   = !wn;
    c.addr = a;
    c.be_n = ben;
    c.wd   = rnd_word();
    c.ce2  = c2;
    hist.push_back(c);
    ce1_ni = c1n; ce2_i = c2; we_ni = wn; be_ni = ben; addr_i = AW'(a);
    old = hist[0];
    wdata_i = (old.sel && old.wr) ? old.wd : rnd_word();
    @(posedge clk_i);
    exp_oe   = old.sel && !old.wr;
    exp_echo = old.ce2;
    if (old.sel && !old.wr) exp_rd = ref_mem[old.addr];
    if (old.sel && old.wr)
      for (int k = 0; k < BYTES; k++)
        if (!old.be_n[k]) ref_mem[old.addr][k*BW +: BW] = old.wd[k*BW +: BW];
    void'(hist.pop_front());
    @(negedge clk_i);
    chk(cur_req, "oe_o", DW'(oe_o), DW'(exp_oe));
    chk("R9", "echo_en_o", DW'(echo_en_o), DW'(exp_echo));
    chk(cur_req, "rdata_o", rdata_o, exp_rd);
  endtask

  task automatic rd(input int a);
    cyc(1'b0, 1'b1, 1'b1, 8'($urandom()), a);
  endtask

  task automatic wr(input int a, input logic [7:0] ben);
    cyc(1'b0, 1'b1, 1'b0, ben, a);
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, 1'b1, 8'hFF, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cmd_t z;
    z.sel = 0; z.wr = 0; z.addr = 0; z.be_n = '1; z.wd = '0; z.ce2 = 0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    hist.push_back(z);
    hist.push_back(z);
    repeat (3) @(negedge clk_i);
    chk("R1", "oe_o in reset", DW'(oe_o), '0);
    chk("R1", "echo_en_o in reset", DW'(echo_en_o), '0);
    chk("R1", "rdata_o in reset", rdata_o, '0);
    rst_ni = 1'b1;

    cur_req = "R1";
    for (int i = 0; i < DEPTH; i++) rd(i);

    cur_req = "R3";
    for (int i = 0; i < DEPTH; i++) wr(i, 8'h00);
    for (int i = 0; i < DEPTH; i++) wr(i, ~(8'h01 << (i % 8)));
    for (int i = 0; i < 3 * DEPTH; i++) wr(i % DEPTH, 8'($urandom()));
    for (int i = 0; i < DEPTH; i++) rd(i);

    cur_req = "R5";
    for (int i = DEPTH - 1; i >= 0; i--) rd(i);
    idle(); idle(); idle();

    cur_req = "R2";
    for (int i = 0; i < DEPTH; i++) rd(i);

    cur_req = "R4";
    for (int i = 0; i < 8; i++) wr(i, 8'hFF);
    for (int i = 0; i < 8; i++) rd(i);

    cur_req = "R6";
    for (int i = 0; i < DEPTH; i++) begin
      wr(i, 8'($urandom())); rd(i);
      wr(i, 8'($urandom())); idle(); rd(i);
      rd(i); wr(i, 8'h00); rd(i);
      wr(i, 8'h0F); wr(i, 8'hF0); rd(i);
    end

    cur_req = "R7";
    for (int i = 0; i < 40; i++) begin
      rd($urandom() % DEPTH);
      wr($urandom() % DEPTH, 8'($urandom()));
    end
    for (int i = 0; i < DEPTH; i++) rd(i);

    cur_req = "R10";
    cyc(1'b1, 1'b1, 1'b0, 8'h00, 5);
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 5);
    cyc(1'b1, 1'b0, 1'b0, 8'h00, 6);
    idle(); rd(5); rd(6);

    cur_req = "R8";
    rd(1); cyc(1'b1, 1'b1, 1'b1, 8'hFF, 1); rd(2); cyc(1'b0, 1'b0, 1'b1, 8'hFF, 2);
    rd(3); idle(); idle(); idle();
    for (int i = 0; i < 400; i++)
      cyc(1'($urandom()), 1'($urandom()), 1'($urandom()),
          8'($urandom()), $urandom() % DEPTH);
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'($urandom()), 1'b0, 8'h00, i % DEPTH);
    for (int i = 0; i < DEPTH; i++) rd(i);
    idle(); idle(); idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule